// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block keeps the interrupt priority state for one hardware thread and drives that thread's interrupt line. It has eight priority levels, and level 0 is the most favored. An event source posts an event at a priority by pulsing `post_valid` with a 3-bit level. The block records the level in an 8-bit pending vector and derives the most favored pending level from that vector. It compares that level with a current priority that software controls. When the pending level is more favored, the block sets an exception-outstanding flag and raises `irq_o`.

Software changes the current priority with a write strobe. It takes an interrupt with an acknowledge read, which returns a status word in the same cycle. When an exception is outstanding, the acknowledge moves the current priority up to the pending level and retires that level's pending bit. The pending vector, the pending level and the current priority are visible on output ports, so the thread can inspect its context.

Top module: `thread_prio_ctx`

## Requirements
- R1: After reset the pending vector is 0, the current priority is 0x00, the pending priority reads 0xFF, `irq_o` is low and the exception flag is clear.
- R2: A post at level p (`post_prio` = p, range 0..7) sets bit p of `ipb_o` at the next clock edge. Posting a level that is already pending leaves the vector unchanged.
- R3: `pipr_o` equals the index of the lowest-numbered set bit of `ipb_o`, zero-extended to 8 bits. It reads 0xFF when no bit is set.
- R4: The exception flag and `irq_o` are high exactly when `pipr_o` is numerically less than `cppr_o`, compared as unsigned 8-bit values. They are re-evaluated on the clock edge that changes either value.
- R5: A write (`cppr_wr` with `cppr_wdata`) loads the current priority at the next edge, and `irq_o` follows in that same cycle. Writing a value equal to or below the pending priority drops `irq_o`.
- R6: An acknowledge read while the exception flag is set does three things at the next edge. It loads the current priority with the pending priority, clears that level's pending bit and clears the exception flag.
- R7: While `ack_rd` is high, `ack_rdata` carries the current priority as it was before the update in bits 7:0. It carries the exception flag in bit 15, and bits 14:8 are zero.
- R8: An acknowledge read while the exception flag is clear changes no state.
- R9: When a post and an acknowledge occur in the same cycle, the post is merged first, and the acknowledge then takes the resulting most favored level.
- R10: When a write and an acknowledge that takes effect occur in the same cycle, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Post an event this cycle |
| post_prio | input | 3 | Priority level of the posted event |
| cppr_wr | input | 1 | Current-priority write strobe |
| cppr_wdata | input | 8 | Current-priority write value |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_rdata | output | 16 | Acknowledge status: {flag, 7'b0, previous current priority} |
| irq_o | output | 1 | Interrupt line to the thread |
| ipb_o | output | 8 | Pending vector |
| pipr_o | output | 8 | Most favored pending priority (0xFF if none) |
| cppr_o | output | 8 | Current priority |

## Verification
The hardest cases to reach are the ones where two actions meet in the same cycle. In one, a post lands while an acknowledge is taken. In the other, a write lands while an acknowledge is taken. In both, the outcome depends on the order in which the block merges the requests. The bench first builds a state in which the exception flag is set and a level is already pending. It then drives the acknowledge together with a post at a more favored level, or together with a current-priority write, in a single cycle. It checks that the more favored level was taken and that the write was dropped. Boundary cases are also covered: a current priority equal to the pending level, and a post at level 7 against a fully unmasked current priority.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
    localparam int PRIO_W     = 8;
    localparam int NUM_PRIO   = 8;
    localparam int EO_BIT     = 7;
    localparam logic [PRIO_W-1:0] NO_PENDING = '1;
endpackage

// File: rtl/tpc_prio_enc.sv
module tpc_prio_enc #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] prio
);
    always_comb begin
        prio = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) prio = W'(i);
        end
    end
endmodule

// File: rtl/tpc_prio_dec.sv
module tpc_prio_dec #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            assign onehot[g] = en && (idx == IW'(g));
        end
    endgenerate
endmodule

// File: rtl/thread_prio_ctx.sv
module thread_prio_ctx #(
    parameter int NUM_PRIO = tpc_pkg::NUM_PRIO,
    parameter int PRIO_W   = tpc_pkg::PRIO_W,
    localparam int IW      = $clog2(NUM_PRIO),
    localparam int RD_W    = 2 * PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_valid,
    input  logic [IW-1:0]     post_prio,
    input  logic              cppr_wr,
    input  logic [PRIO_W-1:0] cppr_wdata,
    input  logic              ack_rd,
    output logic [RD_W-1:0]   ack_rdata,
    output logic              irq_o,
    output logic [NUM_PRIO-1:0] ipb_o,
    output logic [PRIO_W-1:0] pipr_o,
    output logic [PRIO_W-1:0] cppr_o
);
    typedef struct packed {
        logic [NUM_PRIO-1:0] ipb;
        logic [PRIO_W-1:0]   cppr;
        logic                eo;
    } ctx_t;

    ctx_t st_q, st_d;

    logic [NUM_PRIO-1:0] post_vec, clr_vec, ipb_mid, ipb_next;
    logic [PRIO_W-1:0]   pipr_cur, pipr_mid, pipr_next;
    logic                ack_take;

    assign ack_take = ack_rd && st_q.eo;

    tpc_prio_dec #(.N(NUM_PRIO)) u_post_dec (
        .en(post_valid), .idx(post_prio), .onehot(post_vec)
    );

    assign ipb_mid = st_q.ipb | post_vec;

    tpc_prio_enc #(.N(NUM_PRIO), .W(PRIO_W)) u_enc_cur (
        .vec(st_q.ipb), .prio(pipr_cur)
    );

    tpc_prio_enc #(.N(NUM_PRIO), .W(PRIO_W)) u_enc_mid (
        .vec(ipb_mid), .prio(pipr_mid)
    );

    tpc_prio_dec #(.N(NUM_PRIO)) u_clr_dec (
        .en(ack_take), .idx(pipr_mid[IW-1:0]), .onehot(clr_vec)
    );

    assign ipb_next = ipb_mid & ~clr_vec;

    tpc_prio_enc #(.N(NUM_PRIO), .W(PRIO_W)) u_enc_next (
        .vec(ipb_next), .prio(pipr_next)
    );

    // Next-state process: post merged first, then acknowledge, then write.
    always_comb begin
        st_d     = st_q;
        st_d.ipb = ipb_next;
        if (ack_take) begin
            st_d.cppr = pipr_mid;
        end else if (cppr_wr) begin
            st_d.cppr = cppr_wdata;
        end
        st_d.eo = (pipr_next < st_d.cppr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ipb  <= '0;
            st_q.cppr <= '0;
            st_q.eo   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ack_rdata = '0;
        if (ack_rd) begin
            ack_rdata[PRIO_W-1:0]         = st_q.cppr;
            ack_rdata[PRIO_W + tpc_pkg::EO_BIT] = st_q.eo;
        end
    end

    assign irq_o  = st_q.eo;
    assign ipb_o  = st_q.ipb;
    assign pipr_o = pipr_cur;
    assign cppr_o = st_q.cppr;
endmodule

// File: rtl/thread_prio_ctx_chk.sv
module thread_prio_ctx_chk #(
    parameter int NUM_PRIO = tpc_pkg::NUM_PRIO,
    parameter int PRIO_W   = tpc_pkg::PRIO_W,
    localparam int IW      = $clog2(NUM_PRIO),
    localparam int RD_W    = 2 * PRIO_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                post_valid,
    input logic [IW-1:0]       post_prio,
    input logic                cppr_wr,
    input logic                ack_rd,
    input logic [RD_W-1:0]     ack_rdata,
    input logic                irq_o,
    input logic [NUM_PRIO-1:0] ipb_o,
    input logic [PRIO_W-1:0]   pipr_o,
    input logic [PRIO_W-1:0]   cppr_o
);
    assert_empty_pipr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ipb_o == '0) |-> (pipr_o == '1));

    assert_irq_compare_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (pipr_o < cppr_o));

    assert_post_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && !ack_rd) |=> ipb_o[$past(post_prio)]);

    assert_ack_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && irq_o && !post_valid) |=>
        (cppr_o == $past(pipr_o)) && !ipb_o[$past(pipr_o[IW-1:0])] && !irq_o);

    assert_ack_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !irq_o && !post_valid && !cppr_wr) |=>
        $stable(ipb_o) && $stable(cppr_o) && !irq_o);

    assert_ack_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd |-> (ack_rdata == {irq_o, 7'b0, cppr_o}));
endmodule

bind thread_prio_ctx thread_prio_ctx_chk #(
    .NUM_PRIO(NUM_PRIO), .PRIO_W(PRIO_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_prio(post_prio),
    .cppr_wr(cppr_wr), .ack_rd(ack_rd), .ack_rdata(ack_rdata), .irq_o(irq_o),
    .ipb_o(ipb_o), .pipr_o(pipr_o), .cppr_o(cppr_o)
);

// File: tb/thread_prio_ctx_bench.sv
`timescale 1ns/1ps
module thread_prio_ctx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_valid = 1'b0;
    logic [2:0]  post_prio = '0;
    logic        cppr_wr = 1'b0;
    logic [7:0]  cppr_wdata = '0;
    logic        ack_rd = 1'b0;
    logic [15:0] ack_rdata;
    logic        irq_o;
    logic [7:0]  ipb_o, pipr_o, cppr_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    thread_prio_ctx u_thread_prio_ctx (
        .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_prio(post_prio),
        .cppr_wr(cppr_wr), .cppr_wdata(cppr_wdata), .ack_rd(ack_rd),
        .ack_rdata(ack_rdata), .irq_o(irq_o), .ipb_o(ipb_o), .pipr_o(pipr_o),
        .cppr_o(cppr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive after the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        post_valid = 1'b0;
        cppr_wr    = 1'b0;
        ack_rd     = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic post(input logic [2:0] p);
        post_valid = 1'b1; post_prio = p; step();
    endtask

    task automatic wr_cppr(input logic [7:0] v);
        cppr_wr = 1'b1; cppr_wdata = v; step();
    endtask

    task automatic state_is(input string req, input logic [7:0] ipb,
                            input logic [7:0] pipr, input logic [7:0] cppr, input logic irq);
        chk({req, " ipb"},  32'(ipb_o),  32'(ipb));
        chk({req, " pipr"}, 32'(pipr_o), 32'(pipr));
        chk({req, " cppr"}, 32'(cppr_o), 32'(cppr));
        chk({req, " irq"},  32'(irq_o),  32'(irq));
    endtask

    task automatic t_reset_R1();
        do_reset();
        state_is("R1 reset", 8'h00, 8'hFF, 8'h00, 1'b0);
    endtask

    task automatic t_post_masked_R2();
        post(3'd3);
        state_is("R2 post masked", 8'h08, 8'h03, 8'h00, 1'b0);
        post(3'd3);
        chk("R2 repeat post", 32'(ipb_o), 32'h08);
    endtask

    task automatic t_unmask_R5();
        wr_cppr(8'hFF);
        state_is("R5 unmask", 8'h08, 8'h03, 8'hFF, 1'b1);
        post(3'd1);
        state_is("R3 lowest set", 8'h0A, 8'h01, 8'hFF, 1'b1);
    endtask

    task automatic t_ack_R6();
        ack_rd = 1'b1;
        #1;
        chk("R7 ack word eo", 32'(ack_rdata), 32'h80FF);
        step();
        state_is("R6 ack taken", 8'h08, 8'h03, 8'h01, 1'b0);
    endtask

    task automatic t_ack_idle_R8();
        ack_rd = 1'b1;
        #1;
        chk("R7 ack word no eo", 32'(ack_rdata), 32'h0001);
        step();
        state_is("R8 ack idle", 8'h08, 8'h03, 8'h01, 1'b0);
    endtask

    task automatic t_cppr_bound_R4();
        wr_cppr(8'h05);
        state_is("R4 pipr below cppr", 8'h08, 8'h03, 8'h05, 1'b1);
        wr_cppr(8'h03);
        state_is("R5 equal drops irq", 8'h08, 8'h03, 8'h03, 1'b0);
        wr_cppr(8'h05);
        chk("R4 raise again", 32'(irq_o), 32'h1);
    endtask

    task automatic t_post_ack_R9();
        post_valid = 1'b1; post_prio = 3'd0; ack_rd = 1'b1;
        #1;
        chk("R9 ack word", 32'(ack_rdata), 32'h8005);
        step();
        state_is("R9 post then ack", 8'h08, 8'h03, 8'h00, 1'b0);
    endtask

    task automatic t_ack_wr_R10();
        wr_cppr(8'hFF);
        chk("R10 setup irq", 32'(irq_o), 32'h1);
        ack_rd = 1'b1; cppr_wr = 1'b1; cppr_wdata = 8'h10;
        step();
        state_is("R10 write dropped", 8'h00, 8'hFF, 8'h03, 1'b0);
    endtask

    task automatic t_prio7_R2();
        wr_cppr(8'hFF);
        post(3'd7);
        state_is("R2 level 7", 8'h80, 8'h07, 8'hFF, 1'b1);
        post(3'd7);
        chk("R2 level 7 repeat", 32'(ipb_o), 32'h80);
        ack_rd = 1'b1;
        step();
        state_is("R6 level 7 ack", 8'h00, 8'hFF, 8'h07, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_R1();
        t_post_masked_R2();
        t_unmask_R5();
        t_ack_R6();
        t_ack_idle_R8();
        t_cppr_bound_R4();
        t_post_ack_R9();
        t_ack_wr_R10();
        t_prio7_R2();
        t_reset_R1();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule